// File: doc/BRIEF.md
# Configurable Shift-Mask-Permute Execution Stage

This block is a single-cycle 32-bit execution stage. A 256-bit configuration word sets its behaviour, not a fixed opcode. In datapath mode, the first operand is shifted right by a configured amount and then masked. The second operand goes through an arbitrary 32-bit bit permutation and a second mask. The two masked values are ORed to form the result. Each mask comes either from a fixed field of the configuration or from a small pattern generator. The generator offers three alternating-stripe patterns, picked by an external select.

In table mode the same 256 configuration bits act as lookup data. The first operand is split into equal fields of 2, 4 or 8 bits. Each field is used as an index into the configuration, and the entry it finds replaces the field. A typical use is a bit-scatter step of a block cipher. One such setting shifts the first operand right by 4 and keeps its high nibbles (mask 0xF0F0F0F0). It keeps the low nibbles of the permuted second operand (mask 0x0F0F0F0F). Repeated issues of that one configuration, combined with ordinary shifts, build up a full 64-bit bit permutation.

The result and its valid flag are registered. A result appears one cycle after the operands are accepted.

Top module: `cfg_shift_perm_stage`

## Requirements
- R1: While `rst` is high, `out_valid` becomes 0 and `result` becomes 0 at the next rising edge.
- R2: `out_valid` follows `in_valid` with exactly one cycle of latency. `result` loads only on a cycle where `in_valid` is high and holds its value otherwise.
- R3: In datapath mode (`table_mode`=0) the result is `((rs1 >> sh) & MA) | (P(rs2) & MB)`. Here `sh` = cfg[4:0] is a logical right shift, and MA and MB are the effective masks.
- R4: Bit i of P(rs2) equals `rs2[cfg[71+5i +: 5]]` for i = 0..31.
- R5: cfg[69] selects the generated pattern for MA (0 selects the fixed field cfg[36:5]). cfg[70] selects the generated pattern for MB (0 selects the fixed field cfg[68:37]).
- R6: The generated MA pattern is set by `mask_sel`: 0 gives 0xF0F0F0F0, 1 gives 0xFF00FF00, 2 gives 0xFFFF0000, and 3 gives the same as 0. The generated MB pattern is always the bitwise inverse of the generated MA.
- R7: In table mode with `lut_width`=0, each 2-bit field v of rs1 (at bits 2f+1:2f) is replaced by cfg[2v +: 2].
- R8: In table mode with `lut_width`=1, each 4-bit field v of rs1 is replaced by cfg[4v +: 4].
- R9: In table mode with `lut_width`=2 or 3, each byte v of rs1 becomes {7'b0, cfg[v]}.
- R10: In datapath mode with rs1 = 0, the result equals P(rs2) & MB.
- R11: Table mode ignores `rs2` and `mask_sel`. Datapath mode ignores `lut_width`.
- R12: Configuration bits cfg[255:231] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| table_mode | input | 1 | 1 selects table lookup, 0 selects the shift/permute datapath |
| lut_width | input | 2 | Table field width: 0 = 2 bits, 1 = 4 bits, 2 or 3 = 8 bits |
| mask_sel | input | 2 | Pattern generator select |
| cfg | input | 256 | Active configuration word |
| rs1 | input | 32 | First operand (shift path, table source) |
| rs2 | input | 32 | Second operand (permute path) |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Registered result |

## Verification
Every result is due exactly one rising edge after `in_valid` is sampled high. An idle cycle must leave the previous result untouched. The bench applies inputs on the falling edge and computes the expected word from those inputs with a behavioural model. It then waits one rising edge and compares `out_valid` and `result` at the next falling edge. This means each comparison lands in the single cycle where the register has just loaded. Comparisons run on every clock, including idle cycles, where the expected value is the one carried over from the last valid cycle.

// File: rtl/csp_pkg.sv
package csp_pkg;

    parameter int unsigned DW   = 32;
    parameter int unsigned CFGW = 256;
    parameter int unsigned SHW  = $clog2(DW);

    // configuration field offsets
    localparam int unsigned SH_LSB   = 0;
    localparam int unsigned MA_LSB   = SH_LSB + SHW;
    localparam int unsigned MB_LSB   = MA_LSB + DW;
    localparam int unsigned GENA_BIT = MB_LSB + DW;
    localparam int unsigned GENB_BIT = GENA_BIT + 1;
    localparam int unsigned PERM_LSB = GENB_BIT + 1;
    localparam int unsigned PERM_W   = DW * SHW;

    typedef enum logic [1:0] {
        LUT_W2  = 2'd0,
        LUT_W4  = 2'd1,
        LUT_W8  = 2'd2,
        LUT_W8B = 2'd3
    } lut_width_e;

    typedef enum logic [1:0] {
        STRIPE_NIB  = 2'd0,
        STRIPE_BYTE = 2'd1,
        STRIPE_HALF = 2'd2,
        STRIPE_RSVD = 2'd3
    } stripe_e;

    typedef struct packed {
        logic [SHW-1:0]    shamt;
        logic [DW-1:0]     mask_a;
        logic [DW-1:0]     mask_b;
        logic              gen_a;
        logic              gen_b;
        logic [PERM_W-1:0] perm;
    } cfg_fields_t;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } stage_out_t;

    function automatic cfg_fields_t decode_cfg(input logic [CFGW-1:0] c);
        cfg_fields_t f;
        f.shamt  = c[SH_LSB +: SHW];
        f.mask_a = c[MA_LSB +: DW];
        f.mask_b = c[MB_LSB +: DW];
        f.gen_a  = c[GENA_BIT];
        f.gen_b  = c[GENB_BIT];
        f.perm   = c[PERM_LSB +: PERM_W];
        return f;
    endfunction

    // stripe select bit position of the generated mask
    function automatic int unsigned stripe_bit(input stripe_e s);
        case (s)
            STRIPE_BYTE: return 3;
            STRIPE_HALF: return 4;
            default:     return 2;
        endcase
    endfunction

endpackage

// File: rtl/csp_mask_gen.sv
module csp_mask_gen
    import csp_pkg::*;
(
    input  stripe_e       sel,
    output logic [DW-1:0] pat_a,
    output logic [DW-1:0] pat_b
);
    always_comb begin
        int unsigned k;
        k = stripe_bit(sel);
        for (int i = 0; i < DW; i++) begin
            logic [SHW-1:0] pos;
            pos      = SHW'(i);
            pat_a[i] = pos[k];
        end
        pat_b = ~pat_a;
    end
endmodule

// File: rtl/csp_permute.sv
module csp_permute
    import csp_pkg::*;
(
    input  logic [DW-1:0]     din,
    input  logic [PERM_W-1:0] sel,
    output logic [DW-1:0]     dout
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        logic [SHW-1:0] src;
        assign src     = sel[i*SHW +: SHW];
        assign dout[i] = din[src];
    end
endmodule

// File: rtl/csp_table_lookup.sv
module csp_table_lookup
    import csp_pkg::*;
(
    input  logic [DW-1:0]   src,
    input  lut_width_e      width,
    input  logic [CFGW-1:0] tbl,
    output logic [DW-1:0]   dout
);
    logic [DW-1:0] w2, w4, w8;

    always_comb begin
        for (int f = 0; f < DW/2; f++)
            w2[2*f +: 2] = tbl[2*int'(src[2*f +: 2]) +: 2];
        for (int f = 0; f < DW/4; f++)
            w4[4*f +: 4] = tbl[4*int'(src[4*f +: 4]) +: 4];
        for (int f = 0; f < DW/8; f++)
            w8[8*f +: 8] = {7'b0, tbl[src[8*f +: 8]]};
    end

    always_comb begin
        case (width)
            LUT_W2:  dout = w2;
            LUT_W4:  dout = w4;
            default: dout = w8;
        endcase
    end
endmodule

// File: rtl/cfg_shift_perm_stage.sv
module cfg_shift_perm_stage
    import csp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            table_mode,
    input  logic [1:0]      lut_width,
    input  logic [1:0]      mask_sel,
    input  logic [CFGW-1:0] cfg,
    input  logic [DW-1:0]   rs1,
    input  logic [DW-1:0]   rs2,
    output logic            out_valid,
    output logic [DW-1:0]   result
);
    cfg_fields_t   fld;
    logic [DW-1:0] gen_a, gen_b, eff_a, eff_b;
    logic [DW-1:0] shifted, permuted, dp_res, lut_res;
    stage_out_t    nxt, q;

    assign fld = decode_cfg(cfg);

    csp_mask_gen i_mask_gen (
        .sel   (stripe_e'(mask_sel)),
        .pat_a (gen_a),
        .pat_b (gen_b)
    );

    csp_permute i_permute (
        .din  (rs2),
        .sel  (fld.perm),
        .dout (permuted)
    );

    csp_table_lookup i_table (
        .src   (rs1),
        .width (lut_width_e'(lut_width)),
        .tbl   (cfg),
        .dout  (lut_res)
    );

    always_comb begin
        eff_a   = fld.gen_a ? gen_a : fld.mask_a;
        eff_b   = fld.gen_b ? gen_b : fld.mask_b;
        shifted = rs1 >> fld.shamt;
        dp_res  = (shifted & eff_a) | (permuted & eff_b);
        nxt.valid = in_valid;
        nxt.data  = in_valid ? (table_mode ? lut_res : dp_res) : q.data;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign out_valid = q.valid;
    assign result    = q.data;
endmodule

// File: rtl/csp_checks.sv
module csp_checks
    import csp_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            table_mode,
    input logic [1:0]      lut_width,
    input logic [CFGW-1:0] cfg,
    input logic [DW-1:0]   rs1,
    input logic            out_valid,
    input logic [DW-1:0]   result
);
    function automatic logic [DW-1:0] byte_hi_bits();
        logic [DW-1:0] m;
        for (int i = 0; i < DW; i++) m[i] = (i % 8) != 0;
        return m;
    endfunction

    localparam logic [DW-1:0] HI7 = byte_hi_bits();

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> $stable(result));

    p_zero_rs1_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !table_mode && rs1 == '0 && !cfg[GENB_BIT]
         && cfg[MB_LSB +: DW] == '0) |=> (result == '0));

    p_byte_table_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && table_mode && lut_width[1]) |=> ((result & HI7) == '0));
endmodule

bind cfg_shift_perm_stage csp_checks i_csp_checks (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .table_mode (table_mode),
    .lut_width  (lut_width),
    .cfg        (cfg),
    .rs1        (rs1),
    .out_valid  (out_valid),
    .result     (result)
);

// File: tb/test_cfg_shift_perm_stage.sv
`timescale 1ns/1ps
module test_cfg_shift_perm_stage;
    logic         clk = 0;
    logic         rst = 1;
    logic         in_valid = 0, table_mode = 0;
    logic [1:0]   lut_width = 0, mask_sel = 0;
    logic [255:0] cfg = '0;
    logic [31:0]  rs1 = 0, rs2 = 0;
    logic         out_valid;
    logic [31:0]  result;

    int total = 0, bad = 0;
    logic        exp_v = 0;
    logic [31:0] exp_r = 0;
    bit          done = 0;

    cfg_shift_perm_stage i_cfg_shift_perm_stage (
        .clk(clk), .rst(rst), .in_valid(in_valid), .table_mode(table_mode),
        .lut_width(lut_width), .mask_sel(mask_sel), .cfg(cfg),
        .rs1(rs1), .rs2(rs2), .out_valid(out_valid), .result(result)
    );

    always #5 clk = ~clk;

    function automatic logic [255:0] mk(int sh, logic [31:0] ma, logic [31:0] mb,
                                        int src, int kind, int k);
        logic [255:0] c = '0;
        c[4:0]    = sh[4:0];
        c[5 +: 32]  = ma;
        c[37 +: 32] = mb;
        c[69 +: 2]  = src[1:0];
        for (int i = 0; i < 32; i++) begin
            int p;
            p = (kind == 0) ? i : (kind == 1) ? 31 - i : (i + k) % 32;
            c[71 + 5*i +: 5] = p[4:0];
        end
        return c;
    endfunction

    function automatic logic [255:0] rnd_cfg();
        logic [255:0] c;
        for (int w = 0; w < 8; w++) c[32*w +: 32] = $urandom;
        return c;
    endfunction

    function automatic logic [31:0] model(logic tm, logic [1:0] lw, logic [1:0] sel,
                                          logic [255:0] c, logic [31:0] a, logic [31:0] b);
        logic [31:0] r = 0, s, p, ga, ma, mb;
        int k;
        if (tm) begin
            if (lw == 0)
                for (int f = 0; f < 16; f++) begin
                    int v; v = (a >> (2*f)) & 3;
                    r[2*f +: 2] = c[2*v +: 2];
                end
            else if (lw == 1)
                for (int f = 0; f < 8; f++) begin
                    int v; v = (a >> (4*f)) & 15;
                    r[4*f +: 4] = c[4*v +: 4];
                end
            else
                for (int f = 0; f < 4; f++) begin
                    int v; v = (a >> (8*f)) & 255;
                    r[8*f] = c[v];
                end
            return r;
        end
        s = a >> c[4:0];
        k = (sel == 1) ? 8 : (sel == 2) ? 16 : 4;
        for (int i = 0; i < 32; i++) ga[i] = ((i / k) % 2) == 1;
        ma = c[69] ? ga : c[5 +: 32];
        mb = c[70] ? ~ga : c[37 +: 32];
        for (int i = 0; i < 32; i++) p[i] = b[c[71 + 5*i +: 5]];
        return (s & ma) | (p & mb);
    endfunction

    task automatic check(string tag);
        total++;
        if (out_valid !== exp_v || result !== exp_r) begin
            bad++;
            $display("FAIL %s: valid=%0b result=%08h expected valid=%0b result=%08h",
                     tag, out_valid, result, exp_v, exp_r);
        end
    endtask

    task automatic step(string tag, logic v, logic tm, logic [1:0] lw, logic [1:0] sel,
                        logic [255:0] c, logic [31:0] a, logic [31:0] b);
        in_valid = v; table_mode = tm; lut_width = lw; mask_sel = sel;
        cfg = c; rs1 = a; rs2 = b;
        exp_v = v;
        if (v) exp_r = model(tm, lw, sel, c, a, b);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        logic [255:0] ip, c1, c2;
        logic [31:0]  r_first;
        ip = mk(4, 32'hF0F0F0F0, 32'h0F0F0F0F, 0, 0, 0);

        // R1 reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        exp_v = 0; exp_r = 0;
        check("R1");
        rst = 0;

        // R3 scatter configuration, identity permutation
        step("R3", 1, 0, 0, 0, ip, 32'h12345678, 32'h9ABCDEF0);
        step("R3", 1, 0, 0, 0, mk(0, 32'hFFFFFFFF, 0, 0, 0, 0), 32'hCAFEF00D, 32'h1);
        step("R3", 1, 0, 0, 0, mk(31, 32'hFFFFFFFF, 0, 0, 0, 0), 32'h80000000, 32'h0);
        // R4 reversed and rotated permutations, R10 zero rs1
        step("R4", 1, 0, 0, 0, mk(0, 0, 32'hFFFFFFFF, 0, 1, 0), 32'h0, 32'h00000001);
        step("R4", 1, 0, 0, 0, mk(3, 32'h0000FFFF, 32'hFFFFFFFF, 0, 2, 7), 32'hFFFF0000, 32'h13579BDF);
        step("R10", 1, 0, 0, 0, rnd_cfg() & ~(256'd3 << 69), 32'h0, 32'hDEADBEEF);
        step("R10", 1, 0, 0, 2, mk(9, 32'hFFFFFFFF, 32'h00FF00FF, 3, 2, 13), 32'h0, 32'h0F1E2D3C);
        // R2 idle cycle holds result while inputs change
        step("R2", 0, 0, 0, 0, rnd_cfg(), 32'hFFFFFFFF, 32'hFFFFFFFF);
        step("R2", 0, 1, 2, 3, rnd_cfg(), 32'h11111111, 32'h22222222);
        // R5 mask source bits, R6 generator kinds
        step("R5", 1, 0, 0, 0, mk(0, 32'h12345678, 32'h0, 1, 0, 0), 32'hFFFFFFFF, 32'h0);
        step("R5", 1, 0, 0, 1, mk(0, 32'h0, 32'h0, 2, 0, 0), 32'h0, 32'hFFFFFFFF);
        for (int s = 0; s < 4; s++) begin
            step("R6", 1, 0, 0, s[1:0], mk(0, 0, 0, 3, 0, 0), 32'hFFFFFFFF, 32'h0);
            step("R6", 1, 0, 0, s[1:0], mk(0, 0, 0, 3, 0, 0), 32'h0, 32'hFFFFFFFF);
        end
        // R11 datapath ignores lut_width
        step("R11", 1, 0, 3, 0, ip, 32'h12345678, 32'h9ABCDEF0);
        // table modes
        c1 = rnd_cfg();
        step("R7", 1, 1, 0, 0, c1, 32'h1B1B_E4E4, 32'h0);
        step("R8", 1, 1, 1, 0, c1, 32'h0123_CDEF, 32'h0);
        step("R9", 1, 1, 2, 0, c1, 32'hFF80_7F00, 32'h0);
        step("R9", 1, 1, 3, 0, c1, 32'h0102_FEFD, 32'h0);
        // R11 table mode ignores rs2 and mask_sel
        step("R11", 1, 1, 1, 0, c1, 32'h89AB_4567, 32'h0);
        r_first = result;
        step("R11", 1, 1, 1, 3, c1, 32'h89AB_4567, 32'hFFFFFFFF);
        total++;
        if (result !== r_first) begin
            bad++;
            $display("FAIL R11: result=%08h expected %08h", result, r_first);
        end
        // R12 spare configuration bits
        c2 = mk(5, 32'h3C3C3C3C, 32'hC3C3C3C3, 0, 2, 3);
        step("R12", 1, 0, 0, 0, c2, 32'hA5A5_5A5A, 32'h6969_9696);
        r_first = result;
        c2[255:231] = 25'h1FFFFFF;
        step("R12", 1, 0, 0, 0, c2, 32'hA5A5_5A5A, 32'h6969_9696);
        total++;
        if (result !== r_first) begin
            bad++;
            $display("FAIL R12: result=%08h expected %08h", result, r_first);
        end
        // R3 random traffic, mixed modes and idle cycles
        for (int n = 0; n < 400; n++) begin
            logic [31:0] rr;
            rr = $urandom;
            step("R3", rr[0] | rr[1], rr[2], rr[4:3], rr[6:5], rnd_cfg(), $urandom, $urandom);
        end
        // R1 reset in mid-run
        rst = 1;
        in_valid = 1;
        @(posedge clk);
        @(negedge clk);
        exp_v = 0; exp_r = 0;
        check("R1");
        rst = 0;
        in_valid = 0;
        finish_run();
    end
endmodule